// File: doc/BRIEF.md
# Flash-to-FPGA Configuration Loader

This block sits between a byte-wide parallel NOR flash and the 8-bit parallel slave configuration port of an FPGA. After reset it reads a boot switch once and picks one of two images: the primary image at flash address 0 or the fallback image at 0x100_0000. It reads the start of that image to look for a 32-bit sync word. Only when the sync word is found does it pulse the FPGA's program line and wait for the init-ready line. It then streams the image from its base address, one byte per rising edge of a configuration clock that runs at half the reference clock. It stops once the FPGA raises done. If done does not arrive within a byte budget, it reports an error.

The same flash is shared with a host port. Once the loader has settled (no valid image, configured, or failed), the configured FPGA can read bytes from the flash and write bytes to it through the host port. While a boot is in progress the host port is locked out.

States: `S_BOOT` (latch switch) → `S_SCAN` (search sync). From `S_SCAN`, a sync hit leads to `S_PROG`, and a scan window used up without a hit leads to `S_IDLE`. `S_PROG` (program low) → `S_WAITINIT` → `S_STREAM`. From `S_STREAM`, done leads to `S_TAIL` (extra clocks) and then `S_DONE`; a spent byte budget leads to `S_ERROR`. `S_IDLE`, `S_DONE` and `S_ERROR` are terminal until the next reset.

Top module: `cfg_loader`

## Requirements
- R1: `boot_sw[0]` is sampled only in the first cycle after reset. A value of 0 selects the image based at 0x000_0000 and a value of 1 selects the image based at 0x100_0000. Later changes to the switch have no effect, and there is no fallback to the other image.
- R2: `boot_sw[3:1]` have no effect on which image is loaded or on what is streamed.
- R3: An image is valid when the bytes 0xAA, 0x99, 0x55, 0x66 appear at consecutive increasing addresses and the last of them lies within the first 64 bytes of the image. A sync word ending at offset 63 is valid; one ending at offset 64 is not. Without a valid image the loader goes to idle and never drives the port: `cfg_prog_n` stays 1, `cfg_cclk` stays 0, `cfg_oe` stays 0 and `cfg_data` stays 0.
- R4: With a valid image, `cfg_prog_n` is held low for exactly 16 reference clocks and then released.
- R5: No rising edge of `cfg_cclk` occurs until `cfg_init` is high after `cfg_prog_n` has been released.
- R6: While streaming, `cfg_cclk` is high for one reference clock and low for one, so it runs at half the reference rate. `cfg_data` changes only while `cfg_cclk` is low. The n-th rising edge presents image byte n-1, counted from the image base.
- R7: Once `cfg_done` is sampled high, exactly 8 more rising edges of `cfg_cclk` follow. After them the clock rests low, `cfg_oe` drops and `st_done` is set.
- R8: If `byte_limit` rising edges have been delivered and done has not been seen, the loader enters error. Exactly `byte_limit` edges occur in total.
- R9: Exactly one of `st_idle`, `st_loading`, `st_done`, `st_error` is high at all times. `st_loading` is high from reset until the outcome is known.
- R10: `host_gnt` is high only in the idle, done or error outcome. A host request made without the grant never reaches the flash; for example, a write attempted during boot leaves the flash byte unchanged.
- R11: A granted host read returns the flash byte on `host_rdata` with `host_rvalid` high one clock after the request. A granted host write drives `fl_we` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| boot_sw | input | 4 | Boot switch; bit 0 selects the image |
| fl_addr | output | 26 | Flash byte address |
| fl_rd | output | 1 | Flash read strobe; data is returned the next cycle |
| fl_we | output | 1 | Flash write strobe |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_prog_n | output | 1 | Program request to the FPGA, active low |
| cfg_data | output | 8 | Configuration byte |
| cfg_oe | output | 1 | High while the loader owns the configuration port |
| cfg_init | input | 1 | FPGA init-ready |
| cfg_done | input | 1 | FPGA configuration done |
| byte_limit | input | 32 | Byte budget before error |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 26 | Host flash address |
| host_wdata | input | 8 | Host write data |
| host_gnt | output | 1 | Host access permitted |
| host_rdata | output | 8 | Host read data |
| host_rvalid | output | 1 | Host read data valid |
| st_idle | output | 1 | No valid image found |
| st_loading | output | 1 | Boot in progress |
| st_done | output | 1 | FPGA configured |
| st_error | output | 1 | Done not seen within the budget |

## Verification
Boot streaming and host flash access can collide in the same cycle. The bench holds a host write request high from reset through the whole boot. Every cycle it checks that the flash write strobe never rises without a grant. After the outcome it reads the targeted address back through the host port and expects the erased value. A second collision falls at the end of streaming: done is raised in the cycle where a new byte is being loaded. The bench counts the remaining clock edges against the tail length, and the scoreboard verifies every streamed byte before done.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [3:0] {
        S_BOOT,
        S_SCAN,
        S_PROG,
        S_WAITINIT,
        S_STREAM,
        S_TAIL,
        S_IDLE,
        S_DONE,
        S_ERROR
    } ld_state_t;

endpackage

// File: rtl/cfgld_scan.sv
module cfgld_scan
    import cfgld_pkg::*;
#(
    parameter int unsigned        SCAN_LEN  = 64,
    parameter logic [31:0]        SYNC_WORD = 32'hAA99_5566
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              hit,
    output logic              last
);
    localparam int unsigned SH_W = 32 - BYTE_W;
    localparam int unsigned RW   = $clog2(SCAN_LEN + 1);
    localparam int unsigned MIN_SEEN = (32 / BYTE_W) - 1;

    logic [SH_W-1:0] sh;
    logic [RW-1:0]   rcv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            rcv <= '0;
        end else if (clr) begin
            sh  <= '0;
            rcv <= '0;
        end else if (vld) begin
            sh  <= {sh[SH_W-BYTE_W-1:0], byte_in};
            rcv <= rcv + 1'b1;
        end
    end

    assign hit  = vld && (rcv >= RW'(MIN_SEEN)) && ({sh, byte_in} == SYNC_WORD);
    assign last = vld && (rcv == RW'(SCAN_LEN - 1));

endmodule

// File: rtl/cfgld_arb.sv
module cfgld_arb
    import cfgld_pkg::*;
#(
    parameter int unsigned ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_rd,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_rd,
    output logic              fl_we,
    output logic [BYTE_W-1:0] fl_wdata,
    output logic              host_rvalid
);
    logic host_go;
    assign host_go = gnt && host_req;

    always_comb begin
        if (gnt) begin
            fl_addr = host_addr;
            fl_rd   = host_go && !host_we;
            fl_we   = host_go && host_we;
        end else begin
            fl_addr = ld_addr;
            fl_rd   = ld_rd;
            fl_we   = 1'b0;
        end
        fl_wdata = host_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_rvalid <= 1'b0;
        else        host_rvalid <= host_go && !host_we;
    end

endmodule

// File: rtl/cfgld_fsm.sv
module cfgld_fsm
    import cfgld_pkg::*;
#(
    parameter int unsigned ADDR_W     = 26,
    parameter int unsigned SAFE_BASE  = 32'h0100_0000,
    parameter int unsigned SCAN_LEN   = 64,
    parameter int unsigned PROG_LOW   = 16,
    parameter int unsigned TAIL_RISES = 8,
    parameter int unsigned LIM_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_in,
    input  logic [BYTE_W-1:0] fl_rdata,
    input  logic              init_rdy,
    input  logic              done_in,
    input  logic [LIM_W-1:0]  byte_limit,
    input  logic              scan_hit,
    input  logic              scan_last,
    output logic              scan_vld,
    output logic              scan_clr,
    output logic [ADDR_W-1:0] ld_addr,
    output logic              ld_rd,
    output logic              cclk_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              prog_n_o,
    output logic              oe_o,
    output logic              st_idle,
    output logic              st_loading,
    output logic              st_done,
    output logic              st_error,
    output logic              gnt
);
    localparam int unsigned CNT_W = $clog2(SCAN_LEN + PROG_LOW + TAIL_RISES + 2);
    localparam logic [ADDR_W-1:0] ALT_BASE = ADDR_W'(SAFE_BASE);

    ld_state_t         state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [LIM_W-1:0]  nbytes;
    logic              sel_safe, rd, rd_q, cclk, have;
    logic [BYTE_W-1:0] cdata;
    logic [ADDR_W-1:0] addr, img_base;

    assign img_base = sel_safe ? ALT_BASE : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_BOOT;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_BOOT:     nxt = S_SCAN;
            S_SCAN:     if (scan_hit)       nxt = S_PROG;
                        else if (scan_last) nxt = S_IDLE;
            S_PROG:     if (cnt == CNT_W'(PROG_LOW - 1)) nxt = S_WAITINIT;
            S_WAITINIT: if (init_rdy)       nxt = S_STREAM;
            S_STREAM:   if (done_in)        nxt = S_TAIL;
                        else if (nbytes >= byte_limit) nxt = S_ERROR;
            S_TAIL:     if (!cclk && cnt == CNT_W'(TAIL_RISES)) nxt = S_DONE;
            S_IDLE, S_DONE, S_ERROR: nxt = state;
            default:    nxt = S_BOOT;
        endcase
    end

    // datapath: flash fetch, byte latch, configuration clock, counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_safe <= 1'b0;
            rd       <= 1'b0;
            rd_q     <= 1'b0;
            addr     <= '0;
            cnt      <= '0;
            nbytes   <= '0;
            cclk     <= 1'b0;
            have     <= 1'b0;
            cdata    <= '0;
        end else begin
            rd_q <= rd;
            unique case (state)
                S_BOOT: begin
                    sel_safe <= sel_in;
                    addr     <= sel_in ? ALT_BASE : '0;
                    rd       <= 1'b1;
                    cnt      <= CNT_W'(1);
                end
                S_SCAN: begin
                    if (nxt != S_SCAN) begin
                        rd  <= 1'b0;
                        cnt <= '0;
                    end else if (cnt < CNT_W'(SCAN_LEN)) begin
                        rd   <= 1'b1;
                        addr <= addr + 1'b1;
                        cnt  <= cnt + 1'b1;
                    end else begin
                        rd <= 1'b0;
                    end
                end
                S_PROG: begin
                    rd  <= 1'b0;
                    cnt <= cnt + 1'b1;
                end
                S_WAITINIT: begin
                    cnt <= '0;
                    if (init_rdy) begin
                        rd     <= 1'b1;
                        addr   <= img_base;
                        nbytes <= '0;
                        cclk   <= 1'b0;
                        have   <= 1'b0;
                    end
                end
                S_STREAM: begin
                    rd  <= (nxt == S_STREAM) ? ~rd : 1'b0;
                    cnt <= '0;
                    if (rd) addr <= addr + 1'b1;
                    if (rd_q) begin
                        cdata <= fl_rdata;
                        cclk  <= 1'b0;
                        have  <= 1'b1;
                    end else if (have && !done_in) begin
                        cclk   <= 1'b1;
                        nbytes <= nbytes + 1'b1;
                    end
                    if (nxt == S_ERROR) cclk <= 1'b0;
                end
                S_TAIL: begin
                    rd <= 1'b0;
                    if (cclk) begin
                        cclk <= 1'b0;
                    end else if (cnt != CNT_W'(TAIL_RISES)) begin
                        cclk <= 1'b1;
                        cnt  <= cnt + 1'b1;
                    end
                end
                S_IDLE, S_DONE, S_ERROR: begin
                    rd   <= 1'b0;
                    cclk <= 1'b0;
                end
                default: begin
                    rd   <= 1'b0;
                    cclk <= 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        st_idle    = 1'b0;
        st_loading = 1'b0;
        st_done    = 1'b0;
        st_error   = 1'b0;
        oe_o       = 1'b0;
        unique case (state)
            S_BOOT, S_SCAN:                      st_loading = 1'b1;
            S_PROG, S_WAITINIT, S_STREAM, S_TAIL: begin
                st_loading = 1'b1;
                oe_o       = 1'b1;
            end
            S_IDLE:  st_idle  = 1'b1;
            S_DONE:  st_done  = 1'b1;
            S_ERROR: st_error = 1'b1;
            default: st_loading = 1'b1;
        endcase
        prog_n_o = (state != S_PROG);
        cclk_o   = cclk;
        data_o   = oe_o ? cdata : '0;
        gnt      = st_idle | st_done | st_error;
        scan_vld = rd_q && (state == S_SCAN);
        scan_clr = (state == S_BOOT);
        ld_addr  = addr;
        ld_rd    = rd;
    end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfgld_pkg::*;
#(
    parameter int unsigned ADDR_W     = 26,
    parameter int unsigned SAFE_BASE  = 32'h0100_0000,
    parameter int unsigned SCAN_LEN   = 64,
    parameter logic [31:0] SYNC_WORD  = 32'hAA99_5566,
    parameter int unsigned PROG_LOW   = 16,
    parameter int unsigned TAIL_RISES = 8,
    parameter int unsigned LIM_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        boot_sw,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_rd,
    output logic              fl_we,
    output logic [BYTE_W-1:0] fl_wdata,
    input  logic [BYTE_W-1:0] fl_rdata,
    output logic              cfg_cclk,
    output logic              cfg_prog_n,
    output logic [BYTE_W-1:0] cfg_data,
    output logic              cfg_oe,
    input  logic              cfg_init,
    input  logic              cfg_done,
    input  logic [LIM_W-1:0]  byte_limit,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic              host_gnt,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              st_idle,
    output logic              st_loading,
    output logic              st_done,
    output logic              st_error
);
    // only bit 0 of the switch selects the image; the others are reserved
    localparam logic [3:0] SEL_MASK = 4'b0001;

    logic              sel_in, scan_hit, scan_last, scan_vld, scan_clr, ld_rd;
    logic [ADDR_W-1:0] ld_addr;

    assign sel_in     = |(boot_sw & SEL_MASK);
    assign host_rdata = fl_rdata;

    cfgld_scan #(.SCAN_LEN(SCAN_LEN), .SYNC_WORD(SYNC_WORD)) u_scan (
        .clk(clk), .rst_n(rst_n), .clr(scan_clr), .vld(scan_vld),
        .byte_in(fl_rdata), .hit(scan_hit), .last(scan_last)
    );

    cfgld_fsm #(
        .ADDR_W(ADDR_W), .SAFE_BASE(SAFE_BASE), .SCAN_LEN(SCAN_LEN),
        .PROG_LOW(PROG_LOW), .TAIL_RISES(TAIL_RISES), .LIM_W(LIM_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .fl_rdata(fl_rdata),
        .init_rdy(cfg_init), .done_in(cfg_done), .byte_limit(byte_limit),
        .scan_hit(scan_hit), .scan_last(scan_last), .scan_vld(scan_vld),
        .scan_clr(scan_clr), .ld_addr(ld_addr), .ld_rd(ld_rd),
        .cclk_o(cfg_cclk), .data_o(cfg_data), .prog_n_o(cfg_prog_n), .oe_o(cfg_oe),
        .st_idle(st_idle), .st_loading(st_loading), .st_done(st_done),
        .st_error(st_error), .gnt(host_gnt)
    );

    cfgld_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .gnt(host_gnt), .host_req(host_req),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .ld_addr(ld_addr), .ld_rd(ld_rd), .fl_addr(fl_addr), .fl_rd(fl_rd),
        .fl_we(fl_we), .fl_wdata(fl_wdata), .host_rvalid(host_rvalid)
    );

endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
    parameter int unsigned PROG_LOW = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_cclk,
    input logic       cfg_prog_n,
    input logic [7:0] cfg_data,
    input logic       cfg_oe,
    input logic       cfg_init,
    input logic       fl_we,
    input logic       host_req,
    input logic       host_we,
    input logic       host_gnt,
    input logic       host_rvalid,
    input logic       st_idle,
    input logic       st_loading,
    input logic       st_done,
    input logic       st_error
);
    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           low_run <= '0;
        else if (!cfg_prog_n) low_run <= low_run + 1'b1;
        else                  low_run <= '0;
    end

    a_r3_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_oe |-> (!cfg_cclk && cfg_data == 8'h00 && cfg_prog_n));

    a_r4_prog_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_prog_n) |-> (low_run == 16'(PROG_LOW)));

    a_r5_init_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_cclk) |-> cfg_init);

    a_r6_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cclk |=> !cfg_cclk);

    a_r6_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe && $rose(cfg_cclk)) |-> $stable(cfg_data));

    a_r7_done_rest: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> (!cfg_oe && !cfg_cclk));

    a_r9_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({st_idle, st_loading, st_done, st_error}) == 1);

    a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !host_gnt |-> !fl_we);

    a_r11_read_return: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && host_req && !host_we) |=> host_rvalid);

endmodule

bind cfg_loader cfgld_chk #(.PROG_LOW(PROG_LOW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_cclk(cfg_cclk), .cfg_prog_n(cfg_prog_n),
    .cfg_data(cfg_data), .cfg_oe(cfg_oe), .cfg_init(cfg_init), .fl_we(fl_we),
    .host_req(host_req), .host_we(host_we), .host_gnt(host_gnt),
    .host_rvalid(host_rvalid), .st_idle(st_idle), .st_loading(st_loading),
    .st_done(st_done), .st_error(st_error)
);

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;
    localparam int SAFE = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  boot_sw = 4'b0000;
    logic [25:0] fl_addr;
    logic        fl_rd, fl_we;
    logic [7:0]  fl_wdata;
    logic [7:0]  fl_rdata = 8'hFF;
    logic        cfg_cclk, cfg_prog_n, cfg_oe;
    logic [7:0]  cfg_data;
    logic        cfg_init, cfg_done;
    logic [31:0] byte_limit = 32'd1000;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [25:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_gnt, host_rvalid;
    logic [7:0]  host_rdata;
    logic        st_idle, st_loading, st_done, st_error;

    always #2 clk = ~clk;

    cfg_loader u_dut (
        .clk(clk), .rst_n(rst_n), .boot_sw(boot_sw), .fl_addr(fl_addr),
        .fl_rd(fl_rd), .fl_we(fl_we), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .cfg_cclk(cfg_cclk), .cfg_prog_n(cfg_prog_n), .cfg_data(cfg_data),
        .cfg_oe(cfg_oe), .cfg_init(cfg_init), .cfg_done(cfg_done),
        .byte_limit(byte_limit), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_gnt(host_gnt),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .st_idle(st_idle),
        .st_loading(st_loading), .st_done(st_done), .st_error(st_error)
    );

    int checks = 0, errors = 0;
    int done_after = 0;
    int total_rises, tail_rises, prog_low, icnt;
    bit done_seen, cclk_prev;
    logic [7:0] exp_q[$];
    logic [7:0] mem [int];
    int cyc = 0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // flash model: one-cycle read latency, byte writes
    always @(posedge clk) begin
        if (fl_rd) fl_rdata <= mem.exists(int'(fl_addr)) ? mem[int'(fl_addr)] : 8'hFF;
        if (fl_we) mem[int'(fl_addr)] = fl_wdata;
    end

    // FPGA model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            cfg_init = 1'b1; cfg_done = 1'b0; icnt = 0; cclk_prev = 1'b0;
            total_rises = 0; tail_rises = 0; prog_low = 0; done_seen = 1'b0;
        end else begin
            if (!cfg_prog_n) begin
                prog_low++; cfg_init = 1'b0; icnt = 0;
            end else if (!cfg_init) begin
                if (icnt < 5) icnt++; else cfg_init = 1'b1;
            end
            if (!host_gnt && fl_we) chk(1'b0, "R10", "write without grant", 1, 0);
            if (cfg_cclk && !cclk_prev) begin
                total_rises++;
                if (done_seen) tail_rises++;
                chk(cfg_init, "R5", "edge while init low", int'(cfg_init), 1);
                if (exp_q.size() > 0) begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    chk(cfg_data == e, "R6", "streamed byte", cfg_data, e);
                end
                if (done_after != 0 && total_rises == done_after && !done_seen) begin
                    cfg_done = 1'b1; done_seen = 1'b1;
                end
            end
            cclk_prev = cfg_cclk;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "WD", "watchdog expired", cyc, 150000);
            finish_sim();
        end
    end

    function automatic logic [7:0] img_byte(int seed, int k, int soff);
        logic [7:0] v;
        if (soff >= 0 && k >= soff && k < soff + 4) begin
            case (k - soff)
                0: v = 8'hAA;  1: v = 8'h99;  2: v = 8'h55;  default: v = 8'h66;
            endcase
        end else begin
            v = 8'((k * 37 + seed * 101 + 5) & 255);
            if (v == 8'hAA) v = 8'h3C;
        end
        return v;
    endfunction

    // driver: prepares the images and pushes the expected stream
    // outcome: 0 idle, 1 done, 2 error
    task automatic run_case(string name, logic [3:0] sw, int def_sync, int safe_sync,
                            int dafter, int limit, int outcome, bit host_block);
        int sel_sync, sel_seed, n, w;
        mem.delete();
        for (int k = 0; k < 128; k++) begin
            mem[k]        = img_byte(1, k, def_sync);
            mem[SAFE + k] = img_byte(2, k, safe_sync);
        end
        sel_sync = sw[0] ? safe_sync : def_sync;
        sel_seed = sw[0] ? 2 : 1;
        n = (outcome == 1) ? dafter : (outcome == 2) ? limit : 0;
        exp_q.delete();
        for (int k = 0; k < n; k++) exp_q.push_back(img_byte(sel_seed, k, sel_sync));
        done_after = dafter;
        byte_limit = 32'(limit);
        boot_sw    = sw;
        host_req   = host_block; host_we = 1'b1;
        host_addr  = 26'h200_0000; host_wdata = 8'h5A;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(st_loading && !st_idle && !st_done && !st_error, "R9", {name, " reset status"},
            {st_idle, st_loading, st_done, st_error}, 4'b0100);
        chk(!cfg_oe && cfg_prog_n && !host_gnt, "R3", {name, " port released in reset"},
            {cfg_oe, cfg_prog_n, host_gnt}, 3'b010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        boot_sw = ~sw;   // R1: late switch change must not matter
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!(st_idle || st_done || st_error) && w < 4000);
        host_req = 1'b0;
        chk(outcome == 0 ? st_idle : outcome == 1 ? st_done : st_error, "R9",
            {name, " outcome"}, {st_idle, st_loading, st_done, st_error}, outcome);
        chk(exp_q.size() == 0, "R6", {name, " bytes left in scoreboard"}, exp_q.size(), 0);
        chk(prog_low == (outcome == 0 ? 0 : 16), "R4", {name, " program-low cycles"},
            prog_low, outcome == 0 ? 0 : 16);
        if (outcome == 0)
            chk(total_rises == 0 && !cfg_oe, "R3", {name, " no drive without image"}, total_rises, 0);
        if (outcome == 1)
            chk(tail_rises == 8, "R7", {name, " edges after done"}, tail_rises, 8);
        if (outcome == 2)
            chk(total_rises == limit, "R8", {name, " edges before error"}, total_rises, limit);
        repeat (4) @(negedge clk);
        chk(!cfg_cclk && !cfg_oe && host_gnt, "R10", {name, " settled, host granted"},
            {cfg_cclk, cfg_oe, host_gnt}, 3'b001);
    endtask

    task automatic host_write(logic [25:0] a, logic [7:0] d);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        #0;
        chk(fl_we && fl_addr == a, "R11", "write strobe same cycle", fl_we, 1);
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic host_read(logic [25:0] a, logic [7:0] expv, string req);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        chk(host_rvalid && host_rdata == expv, req, "host read data", host_rdata, expv);
    endtask

    initial begin
        // R2: reserved bits set, bit0 = 0, default image loads; host write held during boot
        run_case("A", 4'b1110, 10, 7, 20, 1000, 1, 1'b1);
        host_read(26'h200_0000, 8'hFF, "R10");
        host_write(26'h300_0000, 8'h12);
        host_write(26'h300_0001, 8'hE7);
        host_read(26'h300_0000, 8'h12, "R11");
        host_read(26'h300_0001, 8'hE7, "R11");
        // R1: safety image selected; default image has no sync word
        run_case("B", 4'b0001, -1, 0, 12, 1000, 1, 1'b0);
        // R3: sync word ends at offset 64, outside the window
        run_case("C", 4'b0000, 61, 0, 5, 1000, 0, 1'b0);
        // R3: sync word ends at offset 63, inside the window
        run_case("D", 4'b0000, 60, -1, 5, 1000, 1, 1'b0);
        // R8: done never arrives
        run_case("E", 4'b0000, 3, -1, 0, 30, 2, 1'b0);
        // R1: safety chosen but invalid, no fallback to the valid default
        run_case("F", 4'b0001, 5, -1, 5, 1000, 0, 1'b0);
        finish_sim();
    end

endmodule